// File: doc/BRIEF.md
# Output Index Unscrambler

This block sits at the end of a hybrid transform pipeline. It collects one full frame of N complex results from the short transforms in front of it, which arrive in split-stage order, possibly as several input frames of D samples each. It then sends the frame back out in natural frequency order. A constant index table, computed at elaboration from N and D, chooses which stored word is sent in each output slot. Each stored word is cut down to the final output width.

The block works in two phases. While it is filling, it accepts samples and is never valid on its output. While it is draining, it is valid on its output and refuses input. Both sides use valid/ready. A transfer happens in any cycle where valid and ready are both high. The upstream side must hold its data while `in_ready` is low, and the downstream side may hold `out_ready` low for any number of cycles. While the downstream side stalls, the presented output word and `out_valid` stay unchanged. No transfer is lost in either direction.

Top module: `unscr_top`

## Requirements
- R1: During reset and in the first cycle after it, `in_ready` is 1 and `out_valid` is 0.
- R2: In the fill phase, each accepted sample is stored at the next location in arrival order, 0 to N-1, and `in_ready` stays 1 until N samples are held.
- R3: In the cycle after the N-th sample is accepted, `in_ready` is 0 and `out_valid` is 1.
- R4: Output slot k, counted from 0 within an output frame, carries stored sample map[k].
- R5: The map is defined by a sequence of passes.
  - It starts as the identity.
  - There are log2(N/D) passes, with group size S equal to D, then 2D, and so on.
  - Each pass works on spans of 2S entries starting at p. In each span, entries p and p+2S-1 are kept as they are.
  - For j from 0 to S-2, slot p+1+2j takes the old entry at p+S+j, and slot p+2+2j takes the old entry at p+1+j.
- R6: While `out_valid` is 1 and `out_ready` is 0, the next cycle keeps `out_valid` at 1 and keeps `out_re` and `out_im` unchanged.
- R7: An `in_valid` presented during the drain phase is ignored. Nothing is stored, and the frame being sent is not altered.
- R8: In the cycle after the N-th output transfer, `in_ready` is 1 and `out_valid` is 0, and a new frame fills from location 0.
- R9: Each output part is the low OUT_W bits of the corresponding input part.
- R10: `in_ready` and `out_valid` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Upstream sample is valid |
| in_ready | output | 1 | Block accepts a sample (fill phase) |
| in_re | input | IN_W | Real part of the incoming sample |
| in_im | input | IN_W | Imaginary part of the incoming sample |
| out_valid | output | 1 | Output word is valid (drain phase) |
| out_ready | input | 1 | Downstream accepts the output word |
| out_re | output | OUT_W | Real part, natural order, truncated |
| out_im | output | OUT_W | Imaginary part, natural order, truncated |

## Verification
The phase flags change one clock after the handshake that moves them. The output word follows the read pointer with no extra register. So after the edge that accepts the last input, the first reordered word is due in the very next cycle, and each output transfer brings the next word one cycle later. The bench drives its inputs and checks the outputs at the falling edge. It compares `in_ready`, `out_valid` and, when valid, both data parts against a behavioural model whose state it advances by the handshakes it has just driven. Every comparison therefore lands in the cycle the design's registers have already updated. The stimulus moves from full throughput, to random valid and ready, to long downstream stalls with stray input during drain.

// File: rtl/unscr_pkg.sv
package unscr_pkg;

  typedef enum logic {
    PH_FILL  = 1'b0,
    PH_DRAIN = 1'b1
  } unscr_phase_e;

  // Source location read for output slot k. The passes are undone from the
  // widest group back to the narrowest.
  function automatic int unsigned unscr_src(int unsigned n, int unsigned d,
                                            int unsigned k);
    int unsigned idx;
    int unsigned s;
    int unsigned r;
    int unsigned q;
    idx = k;
    s = n / 2;
    while (s >= d && s > 0) begin
      r = idx % (2 * s);
      if (r != 0 && r != 2 * s - 1) begin
        q = r - 1;
        if (q % 2 == 0) idx = (idx - r) + s + q / 2;
        else            idx = (idx - r) + 1 + q / 2;
      end
      s = s / 2;
    end
    return idx;
  endfunction

endpackage

// File: rtl/unscr_index_rom.sv
module unscr_index_rom #(
  parameter int unsigned N_PTS = 32,
  parameter int unsigned GRP   = 4,
  localparam int unsigned AW   = $clog2(N_PTS)
) (
  input  logic [AW-1:0] slot,
  output logic [AW-1:0] loc
);
  import unscr_pkg::*;

  logic [AW-1:0] tbl [N_PTS];

  for (genvar g = 0; g < N_PTS; g++) begin : g_entry
    localparam int unsigned ENTRY = unscr_src(N_PTS, GRP, g);
    assign tbl[g] = ENTRY[AW-1:0];
  end

  assign loc = tbl[slot];
endmodule

// File: rtl/unscr_store.sv
module unscr_store #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned W     = 32,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/unscr_seq.sv
module unscr_seq #(
  parameter int unsigned N_PTS = 32,
  localparam int unsigned AW   = $clog2(N_PTS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          out_ready,
  output logic          in_ready,
  output logic          out_valid,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] rd_slot
);
  import unscr_pkg::*;

  localparam logic [AW-1:0] LAST = AW'(N_PTS - 1);

  unscr_phase_e  phase;
  logic [AW-1:0] wr_ptr;
  logic [AW-1:0] rd_ptr;
  logic          take_out;

  assign in_ready  = (phase == PH_FILL);
  assign out_valid = (phase == PH_DRAIN);
  assign wr_en     = in_ready && in_valid;
  assign take_out  = out_valid && out_ready;
  assign wr_addr   = wr_ptr;
  assign rd_slot   = rd_ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_FILL;
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else if (wr_en) begin
      if (wr_ptr == LAST) begin
        phase  <= PH_DRAIN;
        wr_ptr <= '0;
        rd_ptr <= '0;
      end else begin
        wr_ptr <= wr_ptr + 1'b1;
      end
    end else if (take_out) begin
      if (rd_ptr == LAST) begin
        phase  <= PH_FILL;
        rd_ptr <= '0;
      end else begin
        rd_ptr <= rd_ptr + 1'b1;
      end
    end
  end
endmodule

// File: rtl/unscr_top.sv
module unscr_top #(
  parameter int unsigned N_PTS = 32,
  parameter int unsigned GRP   = 4,
  parameter int unsigned IN_W  = 24,
  parameter int unsigned OUT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [IN_W-1:0]  in_re,
  input  logic [IN_W-1:0]  in_im,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [OUT_W-1:0] out_re,
  output logic [OUT_W-1:0] out_im
);
  localparam int unsigned AW = $clog2(N_PTS);
  localparam int unsigned WW = 2 * OUT_W;

  logic             wr_en;
  logic [AW-1:0]    wr_addr;
  logic [AW-1:0]    rd_slot;
  logic [AW-1:0]    rd_loc;
  logic [OUT_W-1:0] cut_re;
  logic [OUT_W-1:0] cut_im;
  logic [WW-1:0]    rd_word;

  // Width change on entry, so that the buffer holds only what is sent.
  if (OUT_W <= IN_W) begin : g_cut
    assign cut_re = in_re[OUT_W-1:0];
    assign cut_im = in_im[OUT_W-1:0];
    if (OUT_W < IN_W) begin : g_drop
      logic unused_hi;
      assign unused_hi = ^{in_re[IN_W-1:OUT_W], in_im[IN_W-1:OUT_W]};
    end
  end else begin : g_ext
    assign cut_re = {{(OUT_W-IN_W){in_re[IN_W-1]}}, in_re};
    assign cut_im = {{(OUT_W-IN_W){in_im[IN_W-1]}}, in_im};
  end

  unscr_seq #(.N_PTS(N_PTS)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .out_ready(out_ready),
    .in_ready (in_ready),
    .out_valid(out_valid),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .rd_slot  (rd_slot)
  );

  unscr_index_rom #(.N_PTS(N_PTS), .GRP(GRP)) u_rom (
    .slot(rd_slot),
    .loc (rd_loc)
  );

  unscr_store #(.DEPTH(N_PTS), .W(WW)) u_store (
    .clk  (clk),
    .we   (wr_en),
    .waddr(wr_addr),
    .wdata({cut_re, cut_im}),
    .raddr(rd_loc),
    .rdata(rd_word)
  );

  assign out_re = rd_word[WW-1:OUT_W];
  assign out_im = rd_word[OUT_W-1:0];
endmodule

// File: rtl/unscr_checker.sv
module unscr_checker #(
  parameter int unsigned N_PTS = 32,
  parameter int unsigned OUT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [OUT_W-1:0] out_re,
  input logic [OUT_W-1:0] out_im
);
  int unsigned rx_cnt;
  int unsigned tx_cnt;
  logic        rx_hs;
  logic        tx_hs;

  assign rx_hs = in_valid && in_ready;
  assign tx_hs = out_valid && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_cnt <= 0;
      tx_cnt <= 0;
    end else begin
      if (rx_hs) rx_cnt <= (rx_cnt == N_PTS - 1) ? 0 : rx_cnt + 1;
      if (tx_hs) tx_cnt <= (tx_cnt == N_PTS - 1) ? 0 : tx_cnt + 1;
    end
  end

  AST_PHASE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid)); // R10

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_re) && $stable(out_im))); // R6

  AST_FILL_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_hs && rx_cnt != N_PTS - 1) |=> in_ready); // R2

  AST_FILL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_hs && rx_cnt == N_PTS - 1) |=> (out_valid && !in_ready)); // R3

  AST_DRAIN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_hs && tx_cnt == N_PTS - 1) |=> (in_ready && !out_valid)); // R8

  AST_NO_RX_IN_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && in_valid && !out_ready) |=> out_valid); // R7
endmodule

bind unscr_top unscr_checker #(.N_PTS(N_PTS), .OUT_W(OUT_W)) u_unscr_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_re   (out_re),
  .out_im   (out_im)
);

// File: tb/test_unscr_top.sv
`timescale 1ns/1ps
module test_unscr_top;
  localparam int N     = 32;
  localparam int D     = 4;
  localparam int IN_W  = 24;
  localparam int OUT_W = 16;
  localparam int FRAMES = 8;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             in_valid;
  logic             in_ready;
  logic [IN_W-1:0]  in_re;
  logic [IN_W-1:0]  in_im;
  logic             out_valid;
  logic             out_ready;
  logic [OUT_W-1:0] out_re;
  logic [OUT_W-1:0] out_im;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  unscr_top #(.N_PTS(N), .GRP(D), .IN_W(IN_W), .OUT_W(OUT_W)) i_unscr_top (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_re(in_re), .in_im(in_im), .out_valid(out_valid), .out_ready(out_ready),
    .out_re(out_re), .out_im(out_im)
  );

  int          map_tab [N];
  logic [OUT_W-1:0] ref_re [N];
  logic [OUT_W-1:0] ref_im [N];
  bit filling;
  int wr_n;
  int rd_n;
  int frames_out;

  // Forward construction of the order map (R5).
  task automatic build_map();
    int cur [N];
    int nxt [N];
    int s;
    for (int i = 0; i < N; i++) cur[i] = i;
    s = D;
    while (s < N) begin
      for (int p = 0; p < N; p += 2 * s) begin
        nxt[p] = cur[p];
        nxt[p + 2*s - 1] = cur[p + 2*s - 1];
        for (int j = 0; j < s - 1; j++) begin
          nxt[p + 1 + 2*j] = cur[p + s + j];
          nxt[p + 2 + 2*j] = cur[p + 1 + j];
        end
      end
      cur = nxt;
      s = s * 2;
    end
    map_tab = cur;
  endtask

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    build_map();
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0; in_re = '0; in_im = '0;
    filling = 1; wr_n = 0; rd_n = 0; frames_out = 0;
    repeat (3) @(negedge clk);
    chk(in_ready == 1'b1, "R1 in_ready in reset", in_ready, 1);
    chk(out_valid == 1'b0, "R1 out_valid in reset", out_valid, 0);
    rst_n = 1'b1;
    while (frames_out < FRAMES) begin
      bit      v;
      bit      r;
      @(negedge clk);
      // Compare against the model state after the last edge.
      chk(in_ready == filling, "R2/R3/R8 in_ready", in_ready, filling);
      chk(out_valid == !filling, "R3/R8/R10 out_valid", out_valid, !filling);
      if (!filling) begin
        chk(out_re == ref_re[map_tab[rd_n]], "R4/R5/R6/R7/R9 out_re",
            out_re, ref_re[map_tab[rd_n]]);
        chk(out_im == ref_im[map_tab[rd_n]], "R4/R5/R6/R7/R9 out_im",
            out_im, ref_im[map_tab[rd_n]]);
      end
      // Next stimulus.
      if (frames_out < 2) begin
        v = 1; r = 1;
      end else if (frames_out < 5) begin
        v = $urandom_range(1, 0) == 1;
        r = $urandom_range(1, 0) == 1;
      end else begin
        v = $urandom_range(2, 0) != 0;
        r = $urandom_range(3, 0) == 0;
      end
      in_valid  = v;
      out_ready = r;
      in_re = IN_W'($urandom);
      in_im = IN_W'($urandom);
      // Advance the model by the handshakes of the coming edge.
      if (filling && v) begin
        ref_re[wr_n] = in_re[OUT_W-1:0];
        ref_im[wr_n] = in_im[OUT_W-1:0];
        if (wr_n == N - 1) begin filling = 0; rd_n = 0; wr_n = 0; end
        else wr_n++;
      end else if (!filling && r) begin
        if (rd_n == N - 1) begin filling = 1; rd_n = 0; frames_out++; end
        else rd_n++;
      end
    end
    @(negedge clk);
    chk(in_ready == 1'b1, "R8 in_ready after last frame", in_ready, 1);
    done = 1;
    summary();
    $finish;
  end

  initial begin
    #(8 * 60000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end
endmodule